// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. Each cycle it looks at the pending requests that are not masked. It ranks them against a rotating priority base and compares the best of them with the most urgent line already in service. It raises its interrupt output only when the new request is strictly more urgent. The winning line number is available as a combinational output at all times.

When the processor acknowledges, the block updates its own state on that clock edge. It marks the winner as in service, or, in automatic end-of-interrupt mode, leaves the in-service set alone and may advance the rotation base past the winner. For edge-triggered lines it returns a one-cycle clear strobe to the request-capture logic. One cycle later it presents a registered vector, formed from a programmable upper field and the three-bit line number. An acknowledge that finds no winner is answered with line 7, as a spurious interrupt.

Two exceptions change how the in-service level is computed. In special-mask mode, masked lines do not count as in service. In nested mode on a master instance, the cascade line does not count as in service.

Top module: `rot_irq_resolver`

## Requirements
- R1: A synchronous active-high reset clears the in-service set to 0, sets the rotation base to 0 (line 0 most urgent) and drops vec_valid.
- R2: The rank of line n is (n - base) mod 8, with rank 0 the most urgent. win_line gives the line of lowest rank among pend AND NOT mask, or 7 when irq_out is low.
- R3: irq_out is high exactly when a candidate exists and its rank is strictly lower than the lowest rank in the effective in-service set. An empty in-service set is outranked by any candidate.
- R4: When special_mask is 1, in-service lines whose mask bit is 1 are left out of the effective in-service set.
- R5: When nested_mode and is_master are both 1, in-service bit 2 is left out of the effective in-service set. When either is 0, bit 2 counts like any other bit.
- R6: An acknowledge with irq_out high and auto_eoi 0 sets the in-service bit of win_line on that edge and leaves the base unchanged. The in-service set and base never change without an acknowledge.
- R7: An acknowledge with irq_out high and auto_eoi 1 leaves the in-service set unchanged. If rotate_aeoi is 1, the base becomes (win_line + 1) mod 8; otherwise the base is unchanged.
- R8: ack_clr is one-hot on win_line during an acknowledge with irq_out high when that line's level_mode bit is 0 (edge). It is 0 for a level line (bit 1), for a spurious acknowledge, and whenever ack is 0.
- R9: An acknowledge with irq_out low is spurious: the reported line is 7, and the in-service set and base are unchanged.
- R10: The cycle after an acknowledge, vec_valid is high for one cycle and vec_out equals {vec_base, line}, with vec_base in bits 7:3 and the three-bit line in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend | input | 8 | Pending requests from capture logic |
| mask | input | 8 | Per-line mask, 1 = masked |
| level_mode | input | 8 | Per-line trigger type, 1 = level, 0 = edge |
| special_mask | input | 1 | Leave masked lines out of the in-service level |
| nested_mode | input | 1 | Leave the cascade line out of the in-service level |
| is_master | input | 1 | Instance is the master of a cascade |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rotate_aeoi | input | 1 | Rotate the base on automatic end-of-interrupt |
| vec_base | input | 5 | Upper field of the vector |
| ack | input | 1 | Acknowledge strobe, one cycle |
| irq_out | output | 1 | Interrupt request to the processor |
| win_line | output | 3 | Winning line, 7 when none |
| ack_clr | output | 8 | One-cycle clear for the acknowledged edge line |
| isr_out | output | 8 | In-service set |
| prio_base | output | 3 | Current rotation base |
| vec_valid | output | 1 | Vector valid, the cycle after an acknowledge |
| vec_out | output | 8 | Registered vector |

## Verification
A wrong in-service bit or rotation base shows up at once on irq_out and win_line. Any pending pattern whose rank falls between the true and the corrupted in-service level flips the interrupt decision in the same cycle. A bad base also permutes the winner for nearly every multi-line pattern. A corrupted acknowledge update is visible on isr_out, prio_base and vec_out one edge later. The bench therefore sweeps all 256 pending patterns under every base, then compares each of these outputs against an arithmetic model every cycle of a long mixed-mode run.

// File: rtl/rir_pkg.sv
package rir_pkg;

  typedef struct packed {
    logic auto_eoi;
    logic rotate_aeoi;
    logic special_mask;
    logic nested_mode;
    logic is_master;
  } rir_mode_t;

endpackage

// File: rtl/rir_rank_find.sv
// Lowest rank among set bits, rank measured from a rotating base.
// Returns N (sentinel) when no bit is set.
module rir_rank_find #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  input  logic [LW-1:0] base,
  output logic [LW:0]   rank
);

  logic [N-1:0] rot;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rot
      logic [LW-1:0] src;
      assign src    = LW'(g) + base;
      assign rot[g] = bits[src];
    end
  endgenerate

  always_comb begin
    rank = (LW+1)'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) rank = (LW+1)'(i);
    end
  end

endmodule

// File: rtl/rir_state.sv
// In-service set, rotation base and vector register.
module rir_state
  import rir_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned LW    = $clog2(N),
  parameter int unsigned VEC_W = 8,
  localparam int unsigned BW   = VEC_W - LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  input  logic             win_ok,
  input  logic [LW-1:0]    win_line,
  input  rir_mode_t        mode,
  input  logic [BW-1:0]    vec_base,
  output logic [N-1:0]     isr_q,
  output logic [LW-1:0]    base_q,
  output logic             vec_valid_q,
  output logic [VEC_W-1:0] vec_q
);

  logic [N-1:0] win_hot;
  assign win_hot = N'(1) << win_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q       <= '0;
      base_q      <= '0;
      vec_valid_q <= 1'b0;
      vec_q       <= '0;
    end else begin
      vec_valid_q <= ack;
      if (ack) begin
        vec_q <= {vec_base, win_line};
        if (win_ok) begin
          if (!mode.auto_eoi)
            isr_q <= isr_q | win_hot;
          else if (mode.rotate_aeoi)
            base_q <= win_line + LW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/rot_irq_resolver.sv
module rot_irq_resolver
  import rir_pkg::*;
#(
  parameter int unsigned N         = 8,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned CASC_LINE = 2,
  localparam int unsigned LW       = $clog2(N),
  localparam int unsigned BW       = VEC_W - LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     level_mode,
  input  logic             special_mask,
  input  logic             nested_mode,
  input  logic             is_master,
  input  logic             auto_eoi,
  input  logic             rotate_aeoi,
  input  logic [BW-1:0]    vec_base,
  input  logic             ack,
  output logic             irq_out,
  output logic [LW-1:0]    win_line,
  output logic [N-1:0]     ack_clr,
  output logic [N-1:0]     isr_out,
  output logic [LW-1:0]    prio_base,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out
);

  rir_mode_t     mode;
  logic [N-1:0]  cand, cur_set, sm_keep, casc_keep;
  logic [LW:0]   req_rank, cur_rank;
  logic          win_ok;
  logic [LW-1:0] line_sel;

  assign mode = '{auto_eoi:     auto_eoi,
                  rotate_aeoi:  rotate_aeoi,
                  special_mask: special_mask,
                  nested_mode:  nested_mode,
                  is_master:    is_master};

  assign cand      = pend & ~mask;
  assign sm_keep   = mode.special_mask ? ~mask : '1;
  assign casc_keep = (mode.nested_mode && mode.is_master) ? ~(N'(1) << CASC_LINE) : '1;
  assign cur_set   = isr_out & sm_keep & casc_keep;

  rir_rank_find #(.N(N), .LW(LW)) u_req (
    .bits (cand),
    .base (prio_base),
    .rank (req_rank)
  );

  rir_rank_find #(.N(N), .LW(LW)) u_cur (
    .bits (cur_set),
    .base (prio_base),
    .rank (cur_rank)
  );

  // The sentinel N is above every real rank, so a strict compare covers "none".
  assign win_ok   = req_rank < cur_rank;
  assign line_sel = win_ok ? (req_rank[LW-1:0] + prio_base) : LW'(N - 1);
  assign irq_out  = win_ok;
  assign win_line = line_sel;
  assign ack_clr  = (ack && win_ok) ? ((N'(1) << line_sel) & ~level_mode) : '0;

  rir_state #(.N(N), .LW(LW), .VEC_W(VEC_W)) u_state (
    .clk         (clk),
    .rst         (rst),
    .ack         (ack),
    .win_ok      (win_ok),
    .win_line    (line_sel),
    .mode        (mode),
    .vec_base    (vec_base),
    .isr_q       (isr_out),
    .base_q      (prio_base),
    .vec_valid_q (vec_valid),
    .vec_q       (vec_out)
  );

endmodule

// File: rtl/rir_checker.sv
module rir_checker #(
  parameter int unsigned N     = 8,
  parameter int unsigned LW    = 3,
  parameter int unsigned VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     pend,
  input logic [N-1:0]     mask,
  input logic [N-1:0]     level_mode,
  input logic             auto_eoi,
  input logic [VEC_W-LW-1:0] vec_base,
  input logic             ack,
  input logic             irq_out,
  input logic [LW-1:0]    win_line,
  input logic [N-1:0]     ack_clr,
  input logic [N-1:0]     isr_out,
  input logic [LW-1:0]    prio_base,
  input logic             vec_valid,
  input logic [VEC_W-1:0] vec_out
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (isr_out == '0 && prio_base == '0 && !vec_valid));

  a_r3_irq_needs_candidate: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ((pend & ~mask) != '0));

  a_r6_state_holds: assert property (@(posedge clk) disable iff (rst)
    !ack |=> ($stable(isr_out) && $stable(prio_base)));

  a_r6_marks_in_service: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_out && !auto_eoi) |=> isr_out[$past(win_line)]);

  a_r7_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (rst)
    (ack && auto_eoi) |=> $stable(isr_out));

  a_r8_clear_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_clr) && ((ack_clr & level_mode) == '0));

  a_r8_clear_needs_ack: assert property (@(posedge clk) disable iff (rst)
    !ack |-> (ack_clr == '0));

  a_r9_spurious: assert property (@(posedge clk) disable iff (rst)
    (ack && !irq_out) |=> (vec_out[LW-1:0] == LW'(N - 1) && $stable(isr_out) && $stable(prio_base)));

  a_r10_vector: assert property (@(posedge clk) disable iff (rst)
    ack |=> (vec_valid && vec_out[VEC_W-1:LW] == $past(vec_base)));

endmodule

bind rot_irq_resolver rir_checker #(.N(N), .LW(LW), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pend       (pend),
  .mask       (mask),
  .level_mode (level_mode),
  .auto_eoi   (auto_eoi),
  .vec_base   (vec_base),
  .ack        (ack),
  .irq_out    (irq_out),
  .win_line   (win_line),
  .ack_clr    (ack_clr),
  .isr_out    (isr_out),
  .prio_base  (prio_base),
  .vec_valid  (vec_valid),
  .vec_out    (vec_out)
);

// File: tb/sim_rot_irq_resolver.sv
`timescale 1ns/1ps
module sim_rot_irq_resolver;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pend = '0, mask = '0, level_mode = '0;
  logic       special_mask = 0, nested_mode = 0, is_master = 0;
  logic       auto_eoi = 0, rotate_aeoi = 0, ack = 0;
  logic [4:0] vec_base = '0;
  logic       irq_out, vec_valid;
  logic [2:0] win_line, prio_base;
  logic [7:0] ack_clr, isr_out, vec_out;

  int checks = 0, failures = 0;
  logic [7:0] m_isr = '0;
  int         m_base = 0;
  logic       e_vv = 0;
  logic [7:0] e_vec = '0;

  always #5 clk = ~clk;

  rot_irq_resolver u0 (
    .clk(clk), .rst(rst), .pend(pend), .mask(mask), .level_mode(level_mode),
    .special_mask(special_mask), .nested_mode(nested_mode), .is_master(is_master),
    .auto_eoi(auto_eoi), .rotate_aeoi(rotate_aeoi), .vec_base(vec_base), .ack(ack),
    .irq_out(irq_out), .win_line(win_line), .ack_clr(ack_clr), .isr_out(isr_out),
    .prio_base(prio_base), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic check(string tag, string ctx, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s (%s): actual=%0h expected=%0h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  function automatic int rank_of(int n, int b);
    return (n - b + 8) % 8;
  endfunction

  function automatic int best_rank(logic [7:0] bits, int b);
    int r = 8;
    for (int n = 0; n < 8; n++)
      if (bits[n] && rank_of(n, b) < r) r = rank_of(n, b);
    return r;
  endfunction

  // One acknowledge-capable cycle: inputs already driven, we are just past a negedge.
  task automatic cycle(string ctx);
    logic [7:0] cs;
    int rp, cp, line;
    bit ok;
    logic [7:0] clr;
    #1;
    cs = m_isr;
    if (special_mask) cs = cs & ~mask;
    if (nested_mode && is_master) cs = cs & 8'hFB;
    rp = best_rank(pend & ~mask, m_base);
    cp = best_rank(cs, m_base);
    ok = rp < cp;
    line = 7;
    if (ok)
      for (int n = 0; n < 8; n++) if (rank_of(n, m_base) == rp) line = n;
    clr = (ack && ok && !level_mode[line]) ? (8'd1 << line) : 8'd0;
    check("R3", ctx, irq_out, ok);
    check("R2", ctx, win_line, line);
    check("R8", ctx, ack_clr, clr);
    @(posedge clk);
    e_vv = ack;
    if (ack) begin
      e_vec = {vec_base, 3'(line)};
      if (ok) begin
        if (!auto_eoi) m_isr[line] = 1'b1;
        else if (rotate_aeoi) m_base = (line + 1) % 8;
      end
    end
    @(negedge clk);
    #1;
    check("R6", ctx, isr_out, m_isr);
    check("R7", ctx, prio_base, m_base);
    check("R10", ctx, vec_valid, e_vv);
    if (e_vv) check("R10", ctx, vec_out, e_vec);
  endtask

  task automatic do_reset();
    rst = 1; ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_isr = '0; m_base = 0; e_vv = 0;
    #1;
    check("R1", "reset isr", isr_out, 0);
    check("R1", "reset base", prio_base, 0);
    check("R1", "reset vec_valid", vec_valid, 0);
  endtask

  task automatic clear_modes();
    pend = 0; mask = 0; level_mode = 0; special_mask = 0; nested_mode = 0;
    is_master = 0; auto_eoi = 0; rotate_aeoi = 0; ack = 0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_modes();
    do_reset();
    check("R3", "reset no request", irq_out, 0);

    // R2/R3: every pending pattern under every rotation base
    for (int b = 0; b < 8; b++) begin
      do_reset();
      clear_modes();
      if (b != 0) begin
        pend = 8'd1 << ((b + 7) % 8); auto_eoi = 1; rotate_aeoi = 1; ack = 1;
        cycle("R7 set base");
        clear_modes();
      end
      for (int p = 0; p < 256; p++) begin
        pend = p[7:0];
        mask = ((p * 37) >> 3) & 8'h92;
        cycle("R2 sweep");
      end
    end

    // R4: special mask hides a masked in-service line
    do_reset(); clear_modes();
    pend = 8'h02; ack = 1; cycle("R4 ack line1");
    ack = 0; pend = 8'h08; mask = 8'h02; cycle("R4 sm off blocks");
    check("R4", "sm off irq", irq_out, 0);
    special_mask = 1; cycle("R4 sm on");
    check("R4", "sm on irq", irq_out, 1);
    check("R4", "sm on line", win_line, 3);

    // R5: nested mode on master ignores in-service cascade line
    do_reset(); clear_modes();
    pend = 8'h04; ack = 1; cycle("R5 ack line2");
    ack = 0; is_master = 1; nested_mode = 1; cycle("R5 nested master");
    check("R5", "nested master irq", irq_out, 1);
    nested_mode = 0; cycle("R5 nested off");
    check("R5", "nested off irq", irq_out, 0);
    nested_mode = 1; is_master = 0; cycle("R5 nested slave");
    check("R5", "nested slave irq", irq_out, 0);

    // R7: auto-EOI with and without rotation
    do_reset(); clear_modes();
    pend = 8'h20; auto_eoi = 1; ack = 1; cycle("R7 aeoi no rotate");
    check("R7", "aeoi no rotate base", prio_base, 0);
    rotate_aeoi = 1; cycle("R7 aeoi rotate");
    check("R7", "aeoi rotate base", prio_base, 6);
    check("R7", "aeoi isr", isr_out, 0);

    // R8: level line keeps its request
    do_reset(); clear_modes();
    pend = 8'h10; level_mode = 8'h10; ack = 1; vec_base = 5'h1A; cycle("R8 level ack");

    // R9: spurious acknowledge
    do_reset(); clear_modes();
    pend = 8'h00; ack = 1; vec_base = 5'h05; cycle("R9 spurious empty");
    check("R9", "spurious vec", vec_out, {5'h05, 3'd7});
    pend = 8'h40; mask = 8'h40; cycle("R9 spurious masked");
    check("R9", "spurious isr", isr_out, 0);
    ack = 0; cycle("R10 valid drops");
    check("R10", "vec_valid one cycle", vec_valid, 0);

    // Mixed-mode run against the model
    for (int i = 0; i < 3000; i++) begin
      if (i % 60 == 0) do_reset();
      pend = 8'($urandom); mask = 8'($urandom) & 8'($urandom);
      level_mode = 8'($urandom);
      special_mask = ($urandom % 4) == 0; nested_mode = ($urandom % 3) == 0;
      is_master = $urandom % 2; auto_eoi = ($urandom % 3) == 0;
      rotate_aeoi = $urandom % 2; vec_base = 5'($urandom);
      ack = ($urandom % 3) == 0;
      cycle("mixed");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule